// File: doc/BRIEF.md
# Register-Write Command Buffer Packer

This block turns a stream of register-write requests into the word layout a display register-programming engine later fetches from memory. Each request brings a 20-bit register offset, a 32-bit value and a flag that picks one of two encodings. A direct write becomes a value word and a header word. An indexed write becomes a counted instruction: a count word, a header, then one value word per write. Back-to-back indexed writes to the same register share a single instruction: the new value is appended and the stored count is rewritten.

The packer owns a single write port into a local buffer RAM of `CAP_WORDS` 32-bit words. It keeps a free position and the start of the current instruction. A request turns into up to four word writes, which go out one per cycle while `req_ready` is low. Indexed instructions always begin on an even word (8-byte alignment), and a zero word pads an odd end. A `commit` pulse zero-fills the buffer up to the next 64-byte boundary and reports that boundary as a tail byte offset. The packer then starts again from word 0.

Top module: `regwr_packer`

## Requirements
- R1: After reset `req_ready` is 1, `mem_we` is 0, `tail_valid` is 0 and `overflow` is 0.
- R2: A direct request (`req_indexed`=0) writes the value at the free position F and the header {8'h01, 4'hF, offset} at F+1, and moves F to F+2. `req_ready` stays low while its words go out.
- R3: An indexed request that does not continue the current instruction first rounds F up to even (A). It writes count 1 at A, header {8'h09, 4'h0, offset} at A+1, the value at A+2 and a zero word at A+3. F becomes A+3 and A becomes the instruction start.
- R4: An indexed request that continues the current instruction writes the value at F and the count plus one at the instruction start. If F+1 is odd it also writes a zero word at F+1. F becomes F+1.
- R5: An indexed request continues the current instruction only if the previous accepted request was indexed and used the same offset. A direct request in between always starts a new instruction.
- R6: A request whose words would end beyond `CAP_WORDS` is dropped and causes no write. This includes any request made when F equals `CAP_WORDS`. The drop sets `overflow`, which stays 1 until reset, through commits. Later requests that fit are still accepted.
- R7: A commit with F>0 writes zero to every word from F up to T-1, where T is F rounded up to a multiple of 16 words. It then gives one `tail_valid` pulse with `tail_bytes` = 4*T.
- R8: After a commit, F and the instruction start are 0, and the next indexed request starts a new instruction at word 0 whatever its offset.
- R9: A commit with F=0 causes no write and no `tail_valid` pulse.
- R10: `req_ready` is 0 in every cycle in which `commit` is 1, so no request is taken in a commit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_indexed | input | 1 | 1 = indexed encoding, 0 = direct |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Register value |
| commit | input | 1 | Close the buffer and report the tail |
| mem_we | output | 1 | Buffer RAM write strobe |
| mem_addr | output | $clog2(CAP_WORDS) | Buffer RAM word address |
| mem_wdata | output | 32 | Buffer RAM write data |
| tail_valid | output | 1 | One-cycle pulse: tail_bytes is valid |
| tail_bytes | output | $clog2(CAP_WORDS)+3 | Tail byte offset, a multiple of 64 |
| overflow | output | 1 | Sticky: a request was dropped |

## Verification
The bench walks a sequence that mixes direct writes, a three-write merge, a new instruction after an odd end, and a direct write between two indexed writes to one offset. A packer that skipped the even rounding would put a count word on an odd address. One that merged across the direct write would leave the second header missing. One that forgot the pad would leave stale data where zero is expected. The bench also checks that the first indexed request after a commit starts a fresh instruction, and that an empty commit writes nothing and reports nothing. It fills the buffer to test the two overflow cases: a full buffer, and an indexed request that needs four words when only two remain. A wrong capacity test would either write past the end or refuse a request that still fits.

// File: rtl/regwr_packer_pkg.sv
package regwr_packer_pkg;

    localparam logic [7:0] OP_DIRECT  = 8'h01;
    localparam logic [7:0] OP_INDEXED = 8'h09;
    localparam logic [3:0] ALL_BYTES  = 4'hF;
    localparam int         OFF_W      = 20;
    localparam int         SLOTS      = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } pk_state_e;

endpackage

// File: rtl/regwr_plan.sv
// Works out, for one request, the words to write and the next pointers.
module regwr_plan
    import regwr_packer_pkg::*;
#(
    parameter int CAP_WORDS = 64,
    parameter int PW        = 7
) (
    input  logic [PW-1:0]            fp,
    input  logic [PW-1:0]            start,
    input  logic                     chain_ok,
    input  logic [OFF_W-1:0]         chain_off,
    input  logic [31:0]              count,
    input  logic                     indexed,
    input  logic [OFF_W-1:0]         off,
    input  logic [31:0]              value,
    output logic                     fits,
    output logic [2:0]               n_words,
    output logic [SLOTS-1:0][PW-1:0] slot_a,
    output logic [SLOTS-1:0][31:0]   slot_d,
    output logic [PW-1:0]            fp_nx,
    output logic [PW-1:0]            start_nx,
    output logic [31:0]              count_nx,
    output logic                     chain_nx
);

    localparam logic [PW:0]   CAP_L = (PW+1)'(CAP_WORDS);
    localparam logic [PW-1:0] P1    = PW'(1);
    localparam logic [PW-1:0] P2    = PW'(2);
    localparam logic [PW-1:0] P3    = PW'(3);

    logic [PW-1:0] aligned;
    logic [PW:0]   end_w;
    logic          merge;

    always_comb begin
        aligned  = fp + {{(PW-1){1'b0}}, fp[0]};
        merge    = indexed && chain_ok && (off == chain_off);
        slot_a   = '0;
        slot_d   = '0;
        n_words  = 3'd0;
        fp_nx    = fp;
        start_nx = start;
        count_nx = count;
        chain_nx = chain_ok;
        end_w    = '0;
        if (!indexed) begin
            end_w     = {1'b0, fp} + (PW+1)'(2);
            n_words   = 3'd2;
            slot_a[0] = fp;
            slot_d[0] = value;
            slot_a[1] = fp + P1;
            slot_d[1] = {OP_DIRECT, ALL_BYTES, off};
            fp_nx     = fp + P2;
            start_nx  = fp;
            chain_nx  = 1'b0;
        end else if (merge) begin
            end_w     = {1'b0, fp} + (PW+1)'(1);
            n_words   = fp[0] ? 3'd2 : 3'd3;
            slot_a[0] = fp;
            slot_d[0] = value;
            slot_a[1] = start;
            slot_d[1] = count + 32'd1;
            slot_a[2] = fp + P1;
            slot_d[2] = 32'd0;
            fp_nx     = fp + P1;
            count_nx  = count + 32'd1;
            chain_nx  = 1'b1;
        end else begin
            end_w     = {1'b0, aligned} + (PW+1)'(3);
            n_words   = 3'd4;
            slot_a[0] = aligned;
            slot_d[0] = 32'd1;
            slot_a[1] = aligned + P1;
            slot_d[1] = {OP_INDEXED, 4'h0, off};
            slot_a[2] = aligned + P2;
            slot_d[2] = value;
            slot_a[3] = aligned + P3;
            slot_d[3] = 32'd0;
            fp_nx     = aligned + P3;
            start_nx  = aligned;
            count_nx  = 32'd1;
            chain_nx  = 1'b1;
        end
        fits = (end_w <= CAP_L);
    end

endmodule

// File: rtl/regwr_tail.sv
// Rounds the free position up to the next tail granule.
module regwr_tail #(
    parameter int PW       = 7,
    parameter int GRAN_LOG = 4
) (
    input  logic [PW-1:0] fp,
    output logic [PW-1:0] tail_w,
    output logic          pad_needed
);

    localparam logic [PW:0] ROUND = (PW+1)'((1 << GRAN_LOG) - 1);

    logic [PW:0] sum;

    always_comb begin
        sum        = {1'b0, fp} + ROUND;
        tail_w     = {sum[PW-1:GRAN_LOG], {GRAN_LOG{1'b0}}};
        pad_needed = (tail_w != fp);
    end

endmodule

// File: rtl/regwr_packer.sv
module regwr_packer
    import regwr_packer_pkg::*;
#(
    parameter int CAP_WORDS = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic                           req_indexed,
    input  logic [19:0]                    req_offset,
    input  logic [31:0]                    req_value,
    input  logic                           commit,
    output logic                           mem_we,
    output logic [$clog2(CAP_WORDS)-1:0]   mem_addr,
    output logic [31:0]                    mem_wdata,
    output logic                           tail_valid,
    output logic [$clog2(CAP_WORDS)+2:0]   tail_bytes,
    output logic                           overflow
);

    localparam int AW = $clog2(CAP_WORDS);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] P1 = PW'(1);

    typedef struct packed {
        pk_state_e                st;
        logic [PW-1:0]            fp;
        logic [PW-1:0]            start;
        logic [31:0]              count;
        logic                     chain;
        logic [OFF_W-1:0]         chain_off;
        logic [2:0]               n;
        logic [1:0]               idx;
        logic [SLOTS-1:0][PW-1:0] sa;
        logic [SLOTS-1:0][31:0]   sd;
        logic [PW-1:0]            fptr;
        logic [PW-1:0]            tail_w;
        logic                     ovf;
    } pk_state_t;

    pk_state_t q, nx;

    logic                     p_fits;
    logic [2:0]               p_n;
    logic [SLOTS-1:0][PW-1:0] p_sa;
    logic [SLOTS-1:0][31:0]   p_sd;
    logic [PW-1:0]            p_fp, p_start;
    logic [31:0]              p_count;
    logic                     p_chain;
    logic [PW-1:0]            t_tail;
    logic                     t_pad;

    regwr_plan #(.CAP_WORDS(CAP_WORDS), .PW(PW)) u_plan (
        .fp        (q.fp),
        .start     (q.start),
        .chain_ok  (q.chain),
        .chain_off (q.chain_off),
        .count     (q.count),
        .indexed   (req_indexed),
        .off       (req_offset),
        .value     (req_value),
        .fits      (p_fits),
        .n_words   (p_n),
        .slot_a    (p_sa),
        .slot_d    (p_sd),
        .fp_nx     (p_fp),
        .start_nx  (p_start),
        .count_nx  (p_count),
        .chain_nx  (p_chain)
    );

    regwr_tail #(.PW(PW), .GRAN_LOG(4)) u_tail (
        .fp         (q.fp),
        .tail_w     (t_tail),
        .pad_needed (t_pad)
    );

    always_comb begin
        nx         = q;
        req_ready  = (q.st == ST_IDLE) && !commit;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        tail_valid = 1'b0;
        tail_bytes = {q.tail_w, 2'b00};
        overflow   = q.ovf;
        unique case (q.st)
            ST_IDLE: begin
                if (commit) begin
                    if (q.fp != '0) begin
                        nx.fptr   = q.fp;
                        nx.tail_w = t_tail;
                        nx.st     = t_pad ? ST_FLUSH : ST_DONE;
                    end
                end else if (req_valid) begin
                    if (p_fits) begin
                        nx.st        = ST_EMIT;
                        nx.n         = p_n;
                        nx.idx       = 2'd0;
                        nx.sa        = p_sa;
                        nx.sd        = p_sd;
                        nx.fp        = p_fp;
                        nx.start     = p_start;
                        nx.count     = p_count;
                        nx.chain     = p_chain;
                        nx.chain_off = req_offset;
                    end else begin
                        nx.ovf = 1'b1;
                    end
                end
            end
            ST_EMIT: begin
                mem_we    = 1'b1;
                mem_addr  = q.sa[q.idx][AW-1:0];
                mem_wdata = q.sd[q.idx];
                nx.idx    = q.idx + 2'd1;
                if ({1'b0, q.idx} == (q.n - 3'd1)) nx.st = ST_IDLE;
            end
            ST_FLUSH: begin
                mem_we    = 1'b1;
                mem_addr  = q.fptr[AW-1:0];
                mem_wdata = 32'd0;
                nx.fptr   = q.fptr + P1;
                if ((q.fptr + P1) == q.tail_w) nx.st = ST_DONE;
            end
            ST_DONE: begin
                tail_valid = 1'b1;
                nx.fp      = '0;
                nx.start   = '0;
                nx.count   = '0;
                nx.chain   = 1'b0;
                nx.st      = ST_IDLE;
            end
            default: nx.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nx;
    end

endmodule

// File: rtl/regwr_packer_chk.sv
module regwr_packer_chk #(
    parameter int CAP_WORDS = 64
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic                         commit,
    input logic                         mem_we,
    input logic                         tail_valid,
    input logic [$clog2(CAP_WORDS)+2:0] tail_bytes,
    input logic                         overflow
);

    // R7: reported tail sits on a 64-byte boundary
    a_r7_tail_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |-> (tail_bytes[5:0] == 6'd0));

    // R7: tail report is a single-cycle pulse
    a_r7_tail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |=> !tail_valid);

    // R7: zero fill has ended before the tail is reported
    a_r7_no_write_at_tail: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |-> !mem_we);

    // R6: overflow never clears while out of reset
    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R6: overflow only rises after a presented request
    a_r6_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(req_valid));

    // R2: no request is taken while buffer words are going out
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !req_ready);

    // R8: packer is back to idle after the tail report
    a_r8_idle_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        tail_valid |=> (req_ready || commit));

endmodule

bind regwr_packer regwr_packer_chk #(.CAP_WORDS(CAP_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .commit     (commit),
    .mem_we     (mem_we),
    .tail_valid (tail_valid),
    .tail_bytes (tail_bytes),
    .overflow   (overflow)
);

// File: tb/regwr_packer_tb.sv
`timescale 1ns/1ps
module regwr_packer_tb;

    localparam int CAP = 64;
    localparam int AW  = $clog2(CAP);
    localparam logic [31:0] STALE = 32'hDEADBEEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_indexed = 1'b0, commit = 1'b0;
    logic [19:0] req_offset = '0;
    logic [31:0] req_value = '0;
    logic req_ready, mem_we, tail_valid, overflow;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [AW+2:0] tail_bytes;

    always #5 clk = ~clk;

    regwr_packer #(.CAP_WORDS(CAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_indexed(req_indexed), .req_offset(req_offset), .req_value(req_value),
        .commit(commit), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .tail_valid(tail_valid), .tail_bytes(tail_bytes), .overflow(overflow)
    );

    logic [31:0] tbmem [CAP];
    int wr_cnt = 0, tail_cnt = 0;
    logic [AW+2:0] tail_last = '0;
    int checks = 0, errors = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (mem_we) begin tbmem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
        if (tail_valid) begin tail_cnt <= tail_cnt + 1; tail_last <= tail_bytes; end
    end

    // stimulus table: indexed flag, offset, value, word address the value must land at
    localparam int NV = 7;
    localparam logic        V_IDX [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [19:0] V_OFF [NV] = '{20'h00100, 20'h00200, 20'h00200, 20'h00200,
                                           20'h00300, 20'h00300, 20'h00300};
    localparam logic [31:0] V_VAL [NV] = '{32'hA1A1A1A1, 32'hB1B1B1B1, 32'hB2B2B2B2,
                                           32'hB3B3B3B3, 32'hC1C1C1C1, 32'hD1D1D1D1,
                                           32'hC2C2C2C2};
    localparam int          V_ADR [NV] = '{0, 4, 5, 6, 10, 11, 16};

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_word(input int a, input logic [31:0] exp, input string tag);
        check(tbmem[a] === exp, $sformatf("%s word %0d", tag, a), tbmem[a], exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic idx, input logic [19:0] off, input logic [31:0] val);
        @(negedge clk);
        req_valid = 1'b1; req_indexed = idx; req_offset = off; req_value = val;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        repeat (24) @(negedge clk);
    endtask

    function automatic logic [31:0] hdr_d(input logic [19:0] off);
        return {8'h01, 4'hF, off};
    endfunction
    function automatic logic [31:0] hdr_i(input logic [19:0] off);
        return {8'h09, 4'h0, off};
    endfunction

    initial begin
        int w0, t0;
        for (int i = 0; i < CAP; i++) tbmem[i] = STALE;
        do_reset();

        // R1 reset state
        check(req_ready === 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
        check(mem_we === 1'b0 && tail_valid === 1'b0, "R1 idle outputs",
              {30'd0, mem_we, tail_valid}, 32'd0);
        check(overflow === 1'b0, "R1 overflow", {31'd0, overflow}, 32'd0);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            send(V_IDX[i], V_OFF[i], V_VAL[i]);
            chk_word(V_ADR[i], V_VAL[i], $sformatf("R2/R3/R4 vector %0d", i));
        end
        chk_word(1, hdr_d(20'h00100), "R2 direct header");
        chk_word(12, hdr_d(20'h00300), "R2 direct header after odd end");
        chk_word(3, hdr_i(20'h00200), "R3 indexed header");
        chk_word(2, 32'd3, "R4 merged count");
        chk_word(7, 32'd0, "R4 pad after odd merge");
        chk_word(8, 32'd1, "R3 count on aligned start");
        chk_word(9, hdr_i(20'h00300), "R3 header");
        chk_word(14, 32'd1, "R5 new instruction after direct");
        chk_word(15, hdr_i(20'h00300), "R5 header repeated");
        chk_word(17, 32'd0, "R3 trailing pad");

        // R7 commit: F=17 -> T=32 words, 128 bytes
        t0 = tail_cnt;
        do_commit();
        check(tail_cnt == t0 + 1, "R7 single tail pulse", tail_cnt - t0, 1);
        check(tail_last == 9'd128, "R7 tail bytes", {23'd0, tail_last}, 32'd128);
        for (int a = 18; a < 32; a++) chk_word(a, 32'd0, "R7 zero fill");
        chk_word(32, STALE, "R7 fill stops at tail");

        // R8 fresh start after commit, same offset as an earlier instruction
        send(1'b1, 20'h00300, 32'hE1E1E1E1);
        chk_word(0, 32'd1, "R8 count at word 0");
        chk_word(1, hdr_i(20'h00300), "R8 header at word 1");
        chk_word(2, 32'hE1E1E1E1, "R8 value at word 2");
        chk_word(3, 32'd0, "R8 pad");
        do_commit();
        check(tail_last == 9'd64, "R7 tail bytes small", {23'd0, tail_last}, 32'd64);
        chk_word(15, 32'd0, "R7 zero fill end");

        // R9 empty commit
        w0 = wr_cnt; t0 = tail_cnt;
        do_commit();
        check(wr_cnt == w0, "R9 no writes", wr_cnt - w0, 0);
        check(tail_cnt == t0, "R9 no tail", tail_cnt - t0, 0);

        // R10 ready low in a commit cycle
        @(negedge clk);
        commit = 1'b1; req_valid = 1'b1; req_indexed = 1'b0;
        req_offset = 20'h00555; req_value = 32'h55555555;
        #1;
        check(req_ready === 1'b0, "R10 ready during commit", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        commit = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        chk_word(0, 32'h55555555, "R10 request taken after commit");

        // R6 overflow
        do_reset();
        for (int i = 0; i < 31; i++) send(1'b0, 20'h00040 + 20'(i), 32'(i));
        w0 = wr_cnt;
        send(1'b1, 20'h00777, 32'h77777777);
        check(overflow === 1'b1, "R6 overflow on short room", {31'd0, overflow}, 32'd1);
        check(wr_cnt == w0, "R6 dropped indexed writes nothing", wr_cnt - w0, 0);
        send(1'b0, 20'h00888, 32'h88888888);
        check(wr_cnt == w0 + 2, "R6 fitting request still taken", wr_cnt - w0, 2);
        chk_word(63, hdr_d(20'h00888), "R6 last header");
        w0 = wr_cnt;
        send(1'b0, 20'h00999, 32'h99999999);
        check(wr_cnt == w0, "R6 full buffer drops", wr_cnt - w0, 0);
        t0 = tail_cnt;
        do_commit();
        check(tail_cnt == t0 + 1 && tail_last == 9'd256, "R7 full tail",
              {23'd0, tail_last}, 32'd256);
        check(wr_cnt == w0, "R7 no fill when aligned", wr_cnt - w0, 0);
        check(overflow === 1'b1, "R6 sticky through commit", {31'd0, overflow}, 32'd1);
        do_reset();
        check(overflow === 1'b0, "R6 cleared by reset", {31'd0, overflow}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule